// File: doc/BRIEF.md
# Flash Status Register and Ready/Interrupt Pin Controller

This block holds the 8-bit status register of a parallel NOR flash command interface and drives its single status pin. A command decoder feeds it one-cycle strobes: clear status, and configure pin with a code byte. The write engine feeds it three things. The first is its level indications: busy, erase suspended and program suspended. The second is a set of one-cycle error strobes. The third is a completion strobe that comes with the kind of operation that finished.

The register has two kinds of bits. Some follow the engine's live state and track it every cycle. The error bits are sticky: once set, they stay set until a clear command or reset. The status pin has two modes. By default it shows the engine's ready state as a level. After a configure command it instead idles high and gives a short low pulse when an enabled kind of operation completes. Configure commands are honoured only while the engine is idle and not suspended, and an invalid code is reported through the error bits.

Top module: `flash_stat_ctrl`

## Requirements
- R1: While `rst_n` is low, `status` reads 00h, the pin mode is level ready/busy and `sts_pin` is low. Any pulse configuration is discarded.
- R2: The live bits are registered, so each shows its input one cycle later: bit 7 = NOT `wsm_busy`, bit 6 = `erase_susp`, bit 2 = `prog_susp`. Bit 0 always reads 0.
- R3: The `err_set` strobes set sticky bits: `err_set[0]` sets bit 1, `err_set[1]` sets bit 3, `err_set[2]` sets bit 4, `err_set[3]` sets bit 5. The bit is set one cycle after the strobe and stays set until a clear command or reset.
- R4: `clr_status` zeroes bits 5, 4, 3 and 1 one cycle later. The command works the same in every engine state. A set event in the same cycle wins over the clear.
- R5: In level mode `sts_pin` equals status bit 7. It is low one cycle after `wsm_busy` rises, and high when the engine is ready or suspended.
- R6: A `cfg_cmd` is accepted only when the registered status has bit 7 = 1, bit 6 = 0 and bit 2 = 0. Otherwise it is ignored: the mode does not change and no status bit changes.
- R7: An accepted code with value 00h to 03h sets the mode one cycle later. Code bit 0 enables pulses on erase completion and code bit 1 enables pulses on program completion. Code 00h selects level mode. The mode is kept until the next accepted valid code or reset.
- R8: An accepted code above 03h sets status bits 4 and 5 one cycle later and leaves the mode unchanged.
- R9: In pulse mode `sts_pin` idles high. An enabled completion (`op_done` with `op_kind` 0 = program or 1 = erase) drives the pin low for exactly PULSE_LEN cycles, starting the cycle after the strobe. A new enabled completion restarts the count. An accepted valid code ends any running pulse and has priority over a completion in the same cycle.
- R10: Completions with `op_kind` 2 (set lock bit) or 3 (clear lock bits) never produce a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wsm_busy | input | 1 | Write engine is busy |
| erase_susp | input | 1 | Erase is suspended |
| prog_susp | input | 1 | Program is suspended |
| err_set | input | 4 | One-cycle strobes that set the sticky error bits |
| clr_status | input | 1 | Clear-status command strobe |
| cfg_cmd | input | 1 | Configure-pin command strobe |
| cfg_code | input | 8 | Code byte that comes with `cfg_cmd` |
| op_done | input | 1 | Operation completion strobe |
| op_kind | input | 2 | Kind of the completed operation: 0 program, 1 erase, 2 set lock, 3 clear lock |
| status | output | 8 | Status register |
| sts_pin | output | 1 | Status pin level |

## Verification
The pin mode is the one piece of state that cannot be read directly. A wrong mode shows up in one of two ways. In level mode, `sts_pin` stops following `status[7]` one cycle after busy changes. In pulse mode, a completion produces no low pulse, a pulse of the wrong length, or a pulse for the wrong kind of operation. A wrong error bit shows up on `status` one cycle after the event that caused it. A bit that is lost stays visible as a mismatch on every later cycle until the next clear. Random traffic with idle gaps, together with directed sequences for busy, suspend, invalid codes and lock completions, makes each of these faults visible within a few cycles.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

   localparam int SR_WIDTH   = 8;
   localparam int N_STICKY   = 4;
   localparam int BIT_READY  = 7;
   localparam int BIT_ESUSP  = 6;
   localparam int BIT_EERR   = 5;
   localparam int BIT_PERR   = 4;
   localparam int BIT_SUPPLY = 3;
   localparam int BIT_PSUSP  = 2;
   localparam int BIT_PROT   = 1;

   typedef enum logic [1:0] {
      OP_PROG     = 2'd0,
      OP_ERASE    = 2'd1,
      OP_LOCK_SET = 2'd2,
      OP_LOCK_CLR = 2'd3
   } op_kind_e;

   typedef struct packed {
      logic on_prog;
      logic on_erase;
   } pin_cfg_t;

   // maps sticky strobe index to its status bit position
   function automatic int sticky_pos(input int idx);
      case (idx)
         0:       return BIT_PROT;
         1:       return BIT_SUPPLY;
         2:       return BIT_PERR;
         default: return BIT_EERR;
      endcase
   endfunction

endpackage

// File: rtl/flash_sr_regs.sv
module flash_sr_regs
   import flash_stat_pkg::*;
#(
   parameter int SR_W  = SR_WIDTH,
   parameter int NSTK  = N_STICKY
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            busy_i,
   input  logic            esusp_i,
   input  logic            psusp_i,
   input  logic [NSTK-1:0] err_set_i,
   input  logic            clr_i,
   input  logic            cfg_err_i,
   output logic [SR_W-1:0] sr_o
);

   localparam int N_LIVE = 3;

   generate
      if (SR_W != SR_WIDTH) begin : g_bad_width
         $error("flash_sr_regs: SR_W must equal the package status width");
      end
      if (NSTK != N_STICKY) begin : g_bad_sticky
         $error("flash_sr_regs: NSTK must equal the package sticky count");
      end
   endgenerate

   logic [N_LIVE-1:0] live_q;
   logic [NSTK-1:0]   sticky_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= '0;
      else        live_q <= {~busy_i, esusp_i, psusp_i};
   end

   generate
      for (genvar i = 0; i < NSTK; i++) begin : g_sticky
         localparam int  POS     = sticky_pos(i);
         localparam bit  CFG_HIT = (POS == BIT_PERR) || (POS == BIT_EERR);
         logic set_now;
         assign set_now = err_set_i[i] | (CFG_HIT & cfg_err_i);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sticky_q[i] <= 1'b0;
            else        sticky_q[i] <= set_now | (sticky_q[i] & ~clr_i);
         end
      end
   endgenerate

   always_comb begin
      sr_o            = '0;
      sr_o[BIT_READY] = live_q[2];
      sr_o[BIT_ESUSP] = live_q[1];
      sr_o[BIT_PSUSP] = live_q[0];
      for (int i = 0; i < NSTK; i++) begin
         sr_o[sticky_pos(i)] = sticky_q[i];
      end
   end

endmodule

// File: rtl/flash_cfg_reg.sv
module flash_cfg_reg
   import flash_stat_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int CFG_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              idle_i,
   output pin_cfg_t          cfg_o,
   output logic              load_o,
   output logic              err_o
);

   generate
      if (CFG_BITS != $bits(pin_cfg_t)) begin : g_bad_cfg
         $error("flash_cfg_reg: CFG_BITS must match pin_cfg_t");
      end
      if (CODE_W <= CFG_BITS) begin : g_bad_code
         $error("flash_cfg_reg: CODE_W must exceed CFG_BITS");
      end
   endgenerate

   logic accept;
   logic valid;
   pin_cfg_t cfg_q;

   assign accept = cmd_i & idle_i;
   assign valid  = (code_i[CODE_W-1:CFG_BITS] == '0);
   assign load_o = accept & valid;
   assign err_o  = accept & ~valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (load_o) cfg_q <= pin_cfg_t'(code_i[CFG_BITS-1:0]);
   end

   assign cfg_o = cfg_q;

endmodule

// File: rtl/flash_sts_pulse.sv
module flash_sts_pulse #(
   parameter int PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   input  logic cancel_i,
   output logic active_o
);

   localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN + 1) : 1;

   generate
      if (PULSE_LEN < 1) begin : g_bad_len
         $error("flash_sts_pulse: PULSE_LEN must be at least 1");
      end

      if (PULSE_LEN == 1) begin : g_single
         logic act_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        act_q <= 1'b0;
            else if (cancel_i) act_q <= 1'b0;
            else               act_q <= fire_i;
         end
         assign active_o = act_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cancel_i)      cnt_q <= '0;
            else if (fire_i)        cnt_q <= CNT_W'(PULSE_LEN);
            else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
         end
         assign active_o = (cnt_q != '0);
      end
   endgenerate

endmodule

// File: rtl/flash_stat_ctrl.sv
module flash_stat_ctrl
   import flash_stat_pkg::*;
#(
   parameter int PULSE_LEN = 4,
   parameter int CODE_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wsm_busy,
   input  logic                erase_susp,
   input  logic                prog_susp,
   input  logic [N_STICKY-1:0] err_set,
   input  logic                clr_status,
   input  logic                cfg_cmd,
   input  logic [CODE_W-1:0]   cfg_code,
   input  logic                op_done,
   input  logic [1:0]          op_kind,
   output logic [SR_WIDTH-1:0] status,
   output logic                sts_pin
);

   localparam int CFG_BITS = $bits(pin_cfg_t);

   logic     dev_idle;
   logic     cfg_load;
   logic     cfg_err;
   pin_cfg_t pin_cfg;
   logic     fire;
   logic     pulse_act;
   op_kind_e kind;

   assign dev_idle = status[BIT_READY] & ~status[BIT_ESUSP] & ~status[BIT_PSUSP];

   flash_sr_regs #(
      .SR_W (SR_WIDTH),
      .NSTK (N_STICKY)
   ) u_sr (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy_i    (wsm_busy),
      .esusp_i   (erase_susp),
      .psusp_i   (prog_susp),
      .err_set_i (err_set),
      .clr_i     (clr_status),
      .cfg_err_i (cfg_err),
      .sr_o      (status)
   );

   flash_cfg_reg #(
      .CODE_W   (CODE_W),
      .CFG_BITS (CFG_BITS)
   ) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd_i  (cfg_cmd),
      .code_i (cfg_code),
      .idle_i (dev_idle),
      .cfg_o  (pin_cfg),
      .load_o (cfg_load),
      .err_o  (cfg_err)
   );

   assign kind = op_kind_e'(op_kind);

   always_comb begin
      fire = 1'b0;
      if (op_done) begin
         unique case (kind)
            OP_PROG:     fire = pin_cfg.on_prog;
            OP_ERASE:    fire = pin_cfg.on_erase;
            OP_LOCK_SET,
            OP_LOCK_CLR: fire = 1'b0;
            default:     fire = 1'b0;
         endcase
      end
   end

   flash_sts_pulse #(
      .PULSE_LEN (PULSE_LEN)
   ) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_i   (fire),
      .cancel_i (cfg_load),
      .active_o (pulse_act)
   );

   assign sts_pin = (pin_cfg == '0) ? status[BIT_READY] : ~pulse_act;

endmodule

// File: rtl/flash_stat_ctrl_chk.sv
module flash_stat_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wsm_busy,
   input logic       clr_status,
   input logic       cfg_cmd,
   input logic [7:0] cfg_code,
   input logic       op_done,
   input logic [1:0] op_kind,
   input logic [7:0] status,
   input logic       sts_pin,
   input logic [1:0] cfg_bits
);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |-> (status == 8'h00 && !sts_pin && cfg_bits == 2'b00));

   // R3
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_status |=> ((status & $past(status) & 8'h3A) == ($past(status) & 8'h3A)));

   // R5
   level_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bits == 2'b00 && wsm_busy && !cfg_cmd) |=> !sts_pin);

   // R6
   cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cmd && !status[7]) |=> $stable(cfg_bits));

   // R8
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cmd && status[7] && !status[6] && !status[2] && cfg_code > 8'h03)
      |=> (status[5] && status[4]));

   // R9
   prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bits[1] && op_done && op_kind == 2'd0 && !cfg_cmd) |=> !sts_pin);

   // R10
   lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bits != 2'b00 && sts_pin && op_done && op_kind[1] && !cfg_cmd) |=> sts_pin);

endmodule

bind flash_stat_ctrl flash_stat_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wsm_busy   (wsm_busy),
   .clr_status (clr_status),
   .cfg_cmd    (cfg_cmd),
   .cfg_code   (cfg_code),
   .op_done    (op_done),
   .op_kind    (op_kind),
   .status     (status),
   .sts_pin    (sts_pin),
   .cfg_bits   (pin_cfg)
);

// File: tb/flash_stat_ctrl_bench.sv
module flash_stat_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int PLEN       = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       wsm_busy = 1'b0;
   logic       erase_susp = 1'b0;
   logic       prog_susp = 1'b0;
   logic [3:0] err_set = '0;
   logic       clr_status = 1'b0;
   logic       cfg_cmd = 1'b0;
   logic [7:0] cfg_code = '0;
   logic       op_done = 1'b0;
   logic [1:0] op_kind = '0;
   logic [7:0] status;
   logic       sts_pin;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   logic [7:0] m_sr;
   logic [1:0] m_cfg;
   int         m_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_stat_ctrl #(.PULSE_LEN(PLEN)) u_flash_stat_ctrl (
      .clk(clk), .rst_n(rst_n), .wsm_busy(wsm_busy), .erase_susp(erase_susp),
      .prog_susp(prog_susp), .err_set(err_set), .clr_status(clr_status),
      .cfg_cmd(cfg_cmd), .cfg_code(cfg_code), .op_done(op_done), .op_kind(op_kind),
      .status(status), .sts_pin(sts_pin)
   );

   function automatic logic [7:0] err_map(input logic [3:0] e);
      return {2'b00, e[3], e[2], e[1], 1'b0, e[0], 1'b0};
   endfunction

   function automatic logic exp_pin();
      return (m_cfg == 2'b00) ? m_sr[7] : (m_cnt == 0);
   endfunction

   task automatic model_reset();
      m_sr = '0; m_cfg = '0; m_cnt = 0;
   endtask

   task automatic model_step();
      logic ready, acc, valid, fire;
      logic [7:0] stk;
      ready = m_sr[7] & ~m_sr[6] & ~m_sr[2];
      acc   = cfg_cmd & ready;
      valid = (cfg_code <= 8'h03);
      stk   = clr_status ? 8'h00 : (m_sr & 8'h3A);
      stk   = stk | err_map(err_set);
      if (acc && !valid) stk = stk | 8'h30;
      fire  = op_done && ((op_kind == 2'd0 && m_cfg[1]) || (op_kind == 2'd1 && m_cfg[0]));
      if (acc && valid) begin
         m_cfg = cfg_code[1:0];
         m_cnt = 0;
      end else if (fire) m_cnt = PLEN;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_sr = stk | {~wsm_busy, erase_susp, 3'b000, prog_susp, 2'b00};
   endtask

   task automatic check(input string tag);
      tests++;
      if (status !== m_sr) begin
         fails++;
         $display("FAIL %s status actual %02h expected %02h", tag, status, m_sr);
      end
      tests++;
      if (sts_pin !== exp_pin()) begin
         fails++;
         $display("FAIL %s sts_pin actual %0b expected %0b", tag, sts_pin, exp_pin());
      end
   endtask

   task automatic quiet();
      err_set = '0; clr_status = 0; cfg_cmd = 0; cfg_code = '0; op_done = 0; op_kind = '0;
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(tag);
      quiet();
   endtask

   task automatic do_reset(input string tag);
      rst_n = 0;
      model_reset();
      @(negedge clk);
      check(tag);
      @(negedge clk);
      check(tag);
      quiet();
      rst_n = 1;
   endtask

   task automatic cfg(input logic [7:0] c, input string tag);
      cfg_cmd = 1; cfg_code = c;
      step(tag);
   endtask

   task automatic done(input logic [1:0] k, input string tag);
      op_done = 1; op_kind = k;
      step(tag);
   endtask

   initial begin
      model_reset();
      #1 rst_n = 0;
      do_reset("R1");
      step("R2"); step("R5");

      cfg(8'h02, "R7");
      done(2'd0, "R9");
      for (int i = 0; i < PLEN; i++) step("R9");
      done(2'd2, "R10"); done(2'd3, "R10"); step("R10");
      done(2'd1, "R7"); step("R7");
      done(2'd0, "R9"); step("R9");
      done(2'd0, "R9"); step("R9");
      cfg(8'h02, "R9"); step("R9");

      wsm_busy = 1; step("R2");
      wsm_busy = 1; cfg(8'h00, "R6");
      wsm_busy = 1; cfg(8'h05, "R6");
      step("R6"); step("R6");
      done(2'd0, "R6"); step("R6");

      cfg(8'h07, "R8"); step("R8");
      done(2'd0, "R8"); step("R8");

      err_set = 4'b0100; clr_status = 1; step("R4");
      clr_status = 1; step("R4");
      err_set = 4'b1111; step("R3");
      step("R3"); step("R3");
      clr_status = 1; step("R4");

      erase_susp = 1; step("R2");
      erase_susp = 1; cfg(8'h00, "R6");
      erase_susp = 0; prog_susp = 1; step("R2");
      prog_susp = 1; cfg(8'h01, "R6");
      prog_susp = 0; step("R5");

      cfg(8'h00, "R7");
      wsm_busy = 1; step("R5");
      wsm_busy = 1; step("R5");
      step("R5");
      cfg(8'h01, "R7");
      done(2'd1, "R9");
      do_reset("R1");
      step("R1"); done(2'd1, "R1");

      void'($urandom(32'h5A17));
      for (int n = 0; n < 6000; n++) begin
         wsm_busy   = ($urandom % 3) == 0;
         erase_susp = ($urandom % 16) == 0;
         prog_susp  = ($urandom % 16) == 0;
         err_set    = (($urandom % 10) == 0) ? 4'($urandom) : 4'b0000;
         clr_status = ($urandom % 8) == 0;
         cfg_cmd    = ($urandom % 6) == 0;
         cfg_code   = (($urandom % 5) == 0) ? 8'($urandom) : 8'($urandom % 4);
         op_done    = ($urandom % 4) == 0;
         op_kind    = 2'($urandom);
         step("R2/R3/R4/R5/R6/R7/R8/R9/R10 random");
         if (n == 3000) do_reset("R1");
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule